// File: doc/BRIEF.md
# Translation Lookaside Buffer with Hardware Table Walk

This block maps the page number of a virtual address to a physical frame number. It keeps recent translations in a small fully associative buffer. A single base register locates the page table in main memory. The CPU presents an address on a valid/ready request port. When the page number is resident, the physical address (frame followed by the untouched page offset) is returned in the next cycle.

When the page number is not resident, the block stops accepting requests and reads one page-table entry from memory, at the base register value plus the page number. It then returns the translation and stores the page/frame pair for later use. If the fetched entry is marked invalid, the block returns a fault and stores nothing.

Writing the base register switches the address space: every buffered translation is dropped. When the buffer is full, a pseudo-random slot is chosen to hold the new translation. Empty slots are always used first.

Top module: `tlbw_top`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_req_valid are 0, and no translation is resident, so the first request to any page performs a table read.
- R2: A request whose page number matches a resident entry gets resp_valid in the cycle after acceptance, with resp_paddr = {frame, offset} and resp_fault = 0. It issues no memory read.
- R3: A request that misses issues exactly one memory read: mem_req_valid is high for a single cycle, with mem_req_addr = base + page number (in page-table-entry units).
- R4: From the acceptance of a missing request until its response, req_ready is 0. resp_valid rises in the cycle after the cycle in which mem_resp_valid is sampled high.
- R5: A page-table entry carries its valid flag in bit PFN_W and the frame number in bits PFN_W-1:0. A valid entry produces resp_paddr = {frame, offset}, and the pair is stored so that the next request to that page hits.
- R6: A fetched entry with the valid flag clear produces resp_fault = 1 and resp_paddr = 0. Nothing is stored, so a repeated request to that page performs a new read.
- R7: A cycle with base_we = 1 loads base_wdata into the base register and drops every resident translation. req_ready is 0 during that cycle. Later misses read at the new base.
- R8: While any slot is empty, a new translation goes into an empty slot, so filling ENTRIES distinct pages leaves all of them resident.
- R9: With every slot occupied, a new translation replaces a slot chosen by a free-running pseudo-random sequence. The new translation hits on its next request, and every response stays correct.
- R10: If base_we is asserted while a table read is outstanding, that read's response is still delivered, but its translation is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_vaddr | input | VPN_W+OFF_W | Virtual address: page number above offset |
| resp_valid | output | 1 | Response present (one-cycle pulse) |
| resp_paddr | output | PFN_W+OFF_W | Physical address, zero on fault |
| resp_fault | output | 1 | Page-table entry was invalid |
| mem_req_valid | output | 1 | Page-table read request (one-cycle pulse) |
| mem_req_addr | output | BASE_W | Entry address: base plus page number |
| mem_resp_valid | input | 1 | Read data present |
| mem_resp_data | input | PFN_W+1 | Entry: valid flag in top bit, frame below |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | BASE_W | New base register value |

## Verification
The assertions assume that memory returns exactly one mem_resp_valid pulse for each mem_req_valid pulse, and never before the request. They also assume that mem_resp_data is meaningful only in that pulse. The bench memory model answers each read after a fixed two-cycle delay. It never produces an unrequested response, and it checks that a second read never overlaps an outstanding one. The base register is written only while the block is idle, except in the one deliberate mid-walk write, where the same base value is written again so that the expected frame stays well defined.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_st_e;

    localparam int unsigned LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/tlbw_lfsr.sv
module tlbw_lfsr
    import tlbw_pkg::*;
#(
    parameter int unsigned OUT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [LFSR_W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) begin
            state_d = state_d ^ LFSR_TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LFSR_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/tlbw_cam.sv
module tlbw_cam #(
    parameter int unsigned N     = 64,
    parameter int unsigned KEY_W = 20,
    parameter int unsigned IDX_W = 6
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][KEY_W-1:0] tags,
    input  logic [KEY_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbw_victim.sv
module tlbw_victim #(
    parameter int unsigned N     = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic [N-1:0]     valid,
    input  logic [IDX_W-1:0] rnd,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = rnd;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbw_top.sv
module tlbw_top
    import tlbw_pkg::*;
#(
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PFN_W   = 20,
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned BASE_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr,
    output logic                   resp_valid,
    output logic [PFN_W+OFF_W-1:0] resp_paddr,
    output logic                   resp_fault,
    output logic                   mem_req_valid,
    output logic [BASE_W-1:0]      mem_req_addr,
    input  logic                   mem_resp_valid,
    input  logic [PFN_W:0]         mem_resp_data,
    input  logic                   base_we,
    input  logic [BASE_W-1:0]      base_wdata
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned VA_W  = VPN_W + OFF_W;
    localparam int unsigned PA_W  = PFN_W + OFF_W;

    typedef struct packed {
        walk_st_e                      state;
        logic [VPN_W-1:0]              vpn;
        logic [OFF_W-1:0]              off;
        logic [BASE_W-1:0]             base;
        logic                          drop;
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        logic [ENTRIES-1:0][PFN_W-1:0] frame;
        logic                          resp_valid;
        logic [PA_W-1:0]               resp_paddr;
        logic                          resp_fault;
    } regs_t;

    regs_t d, q;

    logic             cam_hit;
    logic [IDX_W-1:0] cam_idx;
    logic [IDX_W-1:0] rnd_idx;
    logic [IDX_W-1:0] vic_idx;
    logic [VPN_W-1:0] req_vpn;
    logic             accept;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];

    tlbw_cam #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) i_cam (
        .valid (q.valid),
        .tags  (q.tag),
        .key   (req_vpn),
        .hit   (cam_hit),
        .idx   (cam_idx)
    );

    tlbw_lfsr #(.OUT_W(IDX_W)) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd_idx)
    );

    tlbw_victim #(.N(ENTRIES), .IDX_W(IDX_W)) i_victim (
        .valid (q.valid),
        .rnd   (rnd_idx),
        .idx   (vic_idx)
    );

    assign req_ready     = (q.state == ST_IDLE) && !base_we;
    assign accept        = req_valid && req_ready;
    assign mem_req_valid = (q.state == ST_ISSUE);
    assign mem_req_addr  = q.base + BASE_W'(q.vpn);
    assign resp_valid    = q.resp_valid;
    assign resp_paddr    = q.resp_paddr;
    assign resp_fault    = q.resp_fault;

    always_comb begin
        d = q;
        d.resp_valid = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (cam_hit) begin
                        d.resp_valid = 1'b1;
                        d.resp_fault = 1'b0;
                        d.resp_paddr = {q.frame[cam_idx], req_vaddr[OFF_W-1:0]};
                    end else begin
                        d.state = ST_ISSUE;
                        d.vpn   = req_vpn;
                        d.off   = req_vaddr[OFF_W-1:0];
                        d.drop  = 1'b0;
                    end
                end
            end
            ST_ISSUE: begin
                d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_resp_valid) begin
                    d.state      = ST_IDLE;
                    d.resp_valid = 1'b1;
                    if (mem_resp_data[PFN_W]) begin
                        d.resp_fault = 1'b0;
                        d.resp_paddr = {mem_resp_data[PFN_W-1:0], q.off};
                        if (!q.drop) begin
                            d.valid[vic_idx] = 1'b1;
                            d.tag[vic_idx]   = q.vpn;
                            d.frame[vic_idx] = mem_resp_data[PFN_W-1:0];
                        end
                    end else begin
                        d.resp_fault = 1'b1;
                        d.resp_paddr = '0;
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
        if (base_we) begin
            d.base  = base_wdata;
            d.valid = '0;
            if (q.state != ST_IDLE) begin
                d.drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cam_hit) |=> (resp_valid && !resp_fault));

    a_r3_single_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    a_r4_busy_blocks_requests: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    a_r6_fault_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && mem_resp_valid && !mem_resp_data[PFN_W] && !base_we)
        |=> (resp_fault && $stable(q.valid)));

    a_r7_flush_on_base_write: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> (q.valid == '0));
endmodule

// File: tb/test_tlbw_top.sv
module test_tlbw_top;
    localparam int unsigned VPN_W = 8;
    localparam int unsigned PFN_W = 8;
    localparam int unsigned OFF_W = 4;
    localparam int unsigned ENT   = 8;
    localparam int unsigned BW    = 12;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [VPN_W+OFF_W-1:0] req_vaddr = '0;
    logic resp_valid;
    logic [PFN_W+OFF_W-1:0] resp_paddr;
    logic resp_fault;
    logic mem_req_valid;
    logic [BW-1:0] mem_req_addr;
    logic mem_resp_valid = 1'b0;
    logic [PFN_W:0] mem_resp_data = '0;
    logic base_we = 1'b0;
    logic [BW-1:0] base_wdata = '0;

    int checks = 0;
    int errors = 0;
    int reads = 0;
    int pend = 0;
    int last_addr = 0;
    int overlap = 0;
    int busy_ready = 0;
    int cur_base = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tlbw_top #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .ENTRIES(ENT), .BASE_W(BW)) i_tlbw_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .base_we(base_we), .base_wdata(base_wdata)
    );

    function automatic logic [PFN_W-1:0] fr(input int a);
        return PFN_W'(a * 13 + 7);
    endfunction

    function automatic bit pv(input int a);
        return (a % 11) != 5;
    endfunction

    // memory model: answers each read LAT cycles later
    always @(negedge clk) begin
        mem_resp_valid <= 1'b0;
        if (rst_n) begin
            if (pend > 0 || mem_req_valid) begin
                if (req_ready) busy_ready++;
            end
            if (pend > 0) begin
                if (mem_req_valid) overlap++;
                pend = pend - 1;
                if (pend == 0) begin
                    mem_resp_valid <= 1'b1;
                    mem_resp_data  <= {pv(last_addr), fr(last_addr)};
                end
            end else if (mem_req_valid) begin
                reads++;
                last_addr = int'(mem_req_addr);
                pend = LAT;
            end
        end
    end

    task automatic check(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic set_base(input int b);
        @(negedge clk);
        base_we = 1'b1;
        base_wdata = BW'(b);
        #1;
        check(req_ready == 1'b0, "R7 ready low on base write", int'(req_ready), 0);
        @(negedge clk);
        base_we = 1'b0;
        cur_base = b;
    endtask

    task automatic do_req(input int vpn, input int off, input bit exp_hit, input string r,
                          input bit mid_write);
        int r0;
        int lat;
        int a;
        bit v;
        int exp_pa;
        @(negedge clk);
        check(req_ready == 1'b1, r, int'(req_ready), 1);
        r0 = reads;
        req_valid = 1'b1;
        req_vaddr = {VPN_W'(vpn), OFF_W'(off)};
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (mid_write) begin
            base_we = 1'b1;
            base_wdata = BW'(cur_base);
            @(negedge clk);
            base_we = 1'b0;
            lat++;
        end
        while (!resp_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        a = cur_base + vpn;
        v = pv(a);
        exp_pa = v ? ((int'(fr(a)) << OFF_W) | off) : 0;
        check(resp_valid == 1'b1, r, int'(resp_valid), 1);
        check(int'(resp_paddr) == exp_pa, r, int'(resp_paddr), exp_pa);
        check(resp_fault == !v, r, int'(resp_fault), int'(!v));
        check((reads - r0) == (exp_hit ? 0 : 1), r, reads - r0, exp_hit ? 0 : 1);
        check(lat == (exp_hit ? 1 : LAT + 2), r, lat, exp_hit ? 1 : LAT + 2);
        if (!exp_hit) check(last_addr == a, "R3 walk address", last_addr, a);
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);
        check(mem_req_valid == 1'b0, "R1 no read after reset", int'(mem_req_valid), 0);
        set_base(16'h010);
        // R1 R3 R4 R5 R6: first sweep misses; page 0 maps to a faulting entry
        for (int p = 0; p < 8; p++) do_req(p, p ^ 5, 1'b0, "R1 R5 first miss", 1'b0);
        // R2: resident pages hit
        for (int p = 1; p < 8; p++) do_req(p, p, 1'b1, "R2 hit", 1'b0);
        for (int o = 0; o < 16; o++) do_req(1, o, 1'b1, "R2 offset sweep", 1'b0);
        // R6: faulting page was not stored
        do_req(0, 3, 1'b0, "R6 fault not stored", 1'b0);
        // R8: eighth page fills last empty slot, nothing evicted
        do_req(8, 2, 1'b0, "R8 fill", 1'b0);
        for (int p = 1; p < 9; p++) do_req(p, 9, 1'b1, "R8 all resident", 1'b0);
        // R9: full buffer replaces a slot, new translation resident
        do_req(9, 1, 1'b0, "R9 replace", 1'b0);
        do_req(9, 6, 1'b1, "R9 new hit", 1'b0);
        // R7: base write drops everything
        set_base(16'h040);
        do_req(3, 4, 1'b0, "R7 flushed", 1'b0);
        do_req(3, 5, 1'b1, "R7 new base stored", 1'b0);
        // R10: base write during walk, translation not stored
        do_req(4, 7, 1'b0, "R10 walk with write", 1'b1);
        do_req(4, 7, 1'b0, "R10 not stored", 1'b0);
        check(overlap == 0, "R3 no overlapping reads", overlap, 0);
        check(busy_ready == 0, "R4 ready low while walking", busy_ready, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule